// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block supplies the instruction timing for a small microcontroller core. It splits the oscillator into four phase strobes, one per oscillator cycle, so that one instruction cycle lasts four oscillator cycles. Each phase has a fixed job:

- the first phase advances the program counter;
- the second phase strobes an operand read from data memory;
- the fourth phase strobes a destination write;
- the fourth phase also captures the next instruction word from a synchronous program memory.

Fetching overlaps execution. While one instruction executes, the next one is being fetched. A plain instruction therefore costs one instruction cycle.

A core that decodes a taken jump or call raises a branch flag together with a target address. The sequencer samples that flag in the fourth phase of the executing instruction. It then loads the target into the program counter and the fetch address. The word that was prefetched behind the branch is discarded, and its execute slot becomes a forced no-op with its data-memory strobes suppressed. A taken branch therefore costs two instruction cycles.

A clock output toggles at the instruction-cycle rate. The block does not decode instructions and contains no ALU or register file.

Top module: `quad_phase_seq`

## Requirements
- R1: Exactly one bit of `phase` is high in every oscillator cycle. Bit 0 is Q1 and bit 3 is Q4. The bits rotate Q1, Q2, Q3, Q4 and then back to Q1.
- R2: `clkout` is low during Q1 and Q2 and high during Q3 and Q4, so its period is four oscillator cycles.
- R3: Without a taken branch, `pc` rises by one on the clock edge that ends Q1, wrapping from all ones to zero. `pc` holds its value on every other edge.
- R4: When a branch is accepted on the edge that ends Q4, `pc` and `pm_addr` both become `br_target`. `pc` then rises by one at the end of the following Q1.
- R5: On the edge that ends Q4, `pm_addr` is loaded with the current `pc`, unless a branch is accepted. `pm_addr` holds its value for the whole instruction cycle. The program memory returns the word for an address one clock after it sees that address.
- R6: The word captured from `pm_rdata` at the end of Q4 is loaded into `ir` on the edge that ends the next Q1. An instruction fetched in one instruction cycle is therefore visible in `ir` during the next one.
- R7: `dm_rd` is high only during Q2 and `dm_wr` is high only during Q4, in every execute slot except a flushed one.
- R8: After an accepted branch, the next execute slot holds the no-op encoding (all zeros) in `ir`. In that slot `dm_rd` and `dm_wr` stay low. The target instruction reaches `ir` in the slot after that.
- R9: `br_take` has no effect during the flushed no-op slot: neither `pc` nor `pm_addr` changes because of it.
- R10: `br_take` is sampled only in Q4. A high level in Q1, Q2 or Q3 changes neither `pc` nor `pm_addr`.
- R11: While `rst_n` is low, the outputs are:
  - `phase` shows Q1 (value 4'b0001);
  - `pc`, `pm_addr` and `ir` are zero;
  - `clkout`, `dm_rd` and `dm_wr` are low.

  The first two execute slots after reset hold no-ops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_rdata | input | IW | Program-memory read data, valid one clock after `pm_addr` |
| br_take | input | 1 | Executing instruction is a taken jump or call (sampled in Q4) |
| br_target | input | AW | Branch target address |
| phase | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| clkout | output | 1 | Instruction-cycle rate clock, high in Q3 and Q4 |
| pc | output | AW | Program counter |
| pm_addr | output | AW | Program-memory fetch address |
| ir | output | IW | Instruction register |
| dm_rd | output | 1 | Data-memory operand read strobe |
| dm_wr | output | 1 | Data-memory destination write strobe |

## Verification
The assertions assume that the program memory answers exactly one clock after it sees an address. They also assume that `br_target` is stable whenever `br_take` is high in Q4. The bench's memory model registers its output on the same edge the design uses, which keeps the first assumption. The bench drives `br_take` in every phase, including Q1 to Q3 and the flushed slot, so the requirements on ignored branches are exercised and not just assumed. The target values include zero, all ones (to check wrapping) and scattered addresses.

// File: rtl/qps_pkg.sv
package qps_pkg;
    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    localparam int NUM_PHASES = 4;
endpackage

// File: rtl/qps_phase.sv
module qps_phase
    import qps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    output phase_e                ph,
    output logic [NUM_PHASES-1:0] strobe,
    output logic                  clkout
);
    typedef struct packed {
        phase_e ph;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ph = phase_e'(s_q.ph + 2'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_Q1};
        else        s_q <= s_d;
    end

    assign ph = s_q.ph;

    generate
        for (genvar i = 0; i < NUM_PHASES; i++) begin : g_strobe
            assign strobe[i] = (s_q.ph == phase_e'(i));
        end
    endgenerate

    assign clkout = s_q.ph[1];

    p_rotate_q1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        strobe[0] |=> strobe[1]);
    p_rotate_q4_r1: assert property (@(posedge clk) disable iff (!rst_n)
        strobe[3] |=> strobe[0]);
    p_clkout_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clkout) |-> strobe[2]);
endmodule

// File: rtl/qps_fetch.sv
module qps_fetch
    import qps_pkg::*;
#(
    parameter int AW = 10,
    parameter int IW = 12,
    parameter logic [IW-1:0] NOP = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        ph,
    input  logic          br_load,
    input  logic [AW-1:0] br_target,
    input  logic [IW-1:0] pm_rdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] pm_addr,
    output logic [IW-1:0] fetch_word
);
    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] fa;
        logic [IW-1:0] fw;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (ph)
            PH_Q1: s_d.pc = s_q.pc + 1'b1;
            PH_Q4: begin
                s_d.fw = pm_rdata;
                if (br_load) begin
                    s_d.pc = br_target;
                    s_d.fa = br_target;
                end else begin
                    s_d.fa = s_q.pc;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{pc: '0, fa: '0, fw: NOP};
        else        s_q <= s_d;
    end

    assign pc         = s_q.pc;
    assign pm_addr    = s_q.fa;
    assign fetch_word = s_q.fw;

    p_pc_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_Q1) |=> (pc == AW'($past(pc) + 1'b1)));
    p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_Q2 || ph == PH_Q3) |=> $stable(pc));
    p_branch_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_Q4 && br_load) |=> (pc == $past(br_target) && pm_addr == $past(br_target)));
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PH_Q4) |=> $stable(pm_addr));
    p_addr_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_Q4 && !br_load) |=> (pm_addr == $past(pc)));
endmodule

// File: rtl/qps_exec.sv
module qps_exec
    import qps_pkg::*;
#(
    parameter int IW = 12,
    parameter logic [IW-1:0] NOP = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        ph,
    input  logic [IW-1:0] fetch_word,
    input  logic          br_take,
    output logic          br_load,
    output logic [IW-1:0] ir,
    output logic          dm_rd,
    output logic          dm_wr
);
    typedef struct packed {
        logic [IW-1:0] ir;
        logic          flush;
        logic          kill;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        br_load = br_take && (ph == PH_Q4) && !s_q.kill;
        if (ph == PH_Q1) begin
            s_d.ir    = s_q.flush ? NOP : fetch_word;
            s_d.kill  = s_q.flush;
            s_d.flush = 1'b0;
        end
        if (br_load) s_d.flush = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ir: NOP, flush: 1'b0, kill: 1'b0};
        else        s_q <= s_d;
    end

    assign ir    = s_q.ir;
    assign dm_rd = (ph == PH_Q2) && !s_q.kill;
    assign dm_wr = (ph == PH_Q4) && !s_q.kill;

    p_rd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dm_rd |=> (!dm_rd && !dm_wr));
    p_nop_after_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_Q1 && s_q.flush) |=> (ir == NOP && !dm_rd));
    p_kill_one_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_Q1 && s_q.kill) |=> !s_q.kill);
    p_no_wr_killed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_Q1 && s_q.flush) |=> ##2 !dm_wr);
endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq #(
    parameter int AW = 10,
    parameter int IW = 12,
    parameter logic [IW-1:0] NOP = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] pm_rdata,
    input  logic          br_take,
    input  logic [AW-1:0] br_target,
    output logic [3:0]    phase,
    output logic          clkout,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] pm_addr,
    output logic [IW-1:0] ir,
    output logic          dm_rd,
    output logic          dm_wr
);
    import qps_pkg::*;

    phase_e        ph;
    logic          br_load;
    logic [IW-1:0] fetch_word;

    qps_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph     (ph),
        .strobe (phase),
        .clkout (clkout)
    );

    qps_fetch #(.AW(AW), .IW(IW), .NOP(NOP)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph         (ph),
        .br_load    (br_load),
        .br_target  (br_target),
        .pm_rdata   (pm_rdata),
        .pc         (pc),
        .pm_addr    (pm_addr),
        .fetch_word (fetch_word)
    );

    qps_exec #(.IW(IW), .NOP(NOP)) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .ph         (ph),
        .fetch_word (fetch_word),
        .br_take    (br_take),
        .br_load    (br_load),
        .ir         (ir),
        .dm_rd      (dm_rd),
        .dm_wr      (dm_wr)
    );

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);
    p_ignore_early_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase[3] && !phase[0]) |=> ($stable(pc) && $stable(pm_addr)));
endmodule

// File: tb/quad_phase_seq_bench.sv
`timescale 1ns/1ps
module quad_phase_seq_bench;
    localparam int AW   = 10;
    localparam int IW   = 12;
    localparam int NCYC = 800;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] pm_rdata;
    logic          br_take;
    logic [AW-1:0] br_target;
    logic [3:0]    phase;
    logic          clkout;
    logic [AW-1:0] pc;
    logic [AW-1:0] pm_addr;
    logic [IW-1:0] ir;
    logic          dm_rd;
    logic          dm_wr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit reported = 1'b0;

    typedef struct {
        logic [3:0]    ph;
        logic          ck;
        logic [AW-1:0] pc;
        logic [AW-1:0] fa;
        logic [IW-1:0] ir;
        logic          rd;
        logic          wr;
        string         pc_tag;
        string         ir_tag;
        string         dm_tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    quad_phase_seq u_quad_phase_seq (
        .clk(clk), .rst_n(rst_n), .pm_rdata(pm_rdata), .br_take(br_take),
        .br_target(br_target), .phase(phase), .clkout(clkout), .pc(pc),
        .pm_addr(pm_addr), .ir(ir), .dm_rd(dm_rd), .dm_wr(dm_wr)
    );

    function automatic logic [IW-1:0] mem_word(logic [AW-1:0] a);
        return {2'b01, a};
    endfunction

    always_ff @(posedge clk) pm_rdata <= mem_word(pm_addr);

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    // Driver: reference model of the phase/fetch/execute timing, pushes expectations
    initial begin
        logic [1:0]    m_ph;
        logic [AW-1:0] m_pc, m_fa, tgt;
        logic [IW-1:0] m_fw, m_ir, m_rd_reg, rd_next;
        logic          m_flush, m_kill, bt;
        logic [15:0]   lfsr;
        string         pc_tag, ir_tag;
        exp_t          e;

        br_take = 1'b0;
        br_target = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "phase", 32'(phase), 32'h1);
        chk("R11", "pc", 32'(pc), 32'h0);
        chk("R11", "pm_addr", 32'(pm_addr), 32'h0);
        chk("R11", "ir", 32'(ir), 32'h0);
        chk("R11", "clkout/rd/wr", 32'({clkout, dm_rd, dm_wr}), 32'h0);
        rst_n = 1'b1;

        m_ph = 2'd0; m_pc = '0; m_fa = '0; m_fw = '0; m_ir = '0;
        m_flush = 1'b0; m_kill = 1'b0; m_rd_reg = mem_word('0);
        lfsr = 16'hACE1;
        pc_tag = "R11"; ir_tag = "R11";

        for (int n = 0; n < NCYC; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bt  = lfsr[0] & lfsr[3];
            tgt = lfsr[15:6];
            if (n >= 300 && n < 340) begin bt = 1'b1; tgt = '1; end
            if (n >= 500 && n < 530) begin bt = 1'b1; tgt = '0; end
            if (n >= 600 && n < 680) bt = 1'b0;
            br_take = bt;
            br_target = tgt;

            e.ph = 4'(1 << m_ph);
            e.ck = m_ph[1];
            e.pc = m_pc;
            e.fa = m_fa;
            e.ir = m_ir;
            e.rd = (m_ph == 2'd1) && !m_kill;
            e.wr = (m_ph == 2'd3) && !m_kill;
            e.pc_tag = pc_tag;
            e.ir_tag = ir_tag;
            e.dm_tag = m_kill ? "R8" : "R7";
            sb.push_back(e);

            // tags for the following cycle's checks
            if (bt && m_ph == 2'd3 && m_kill)      pc_tag = "R9";
            else if (bt && m_ph == 2'd3)           pc_tag = "R4";
            else if (bt)                           pc_tag = "R10";
            else                                   pc_tag = "R3";
            if (m_ph == 2'd0 && m_flush)           ir_tag = "R8";
            else if (m_ph == 2'd0)                 ir_tag = "R6";

            // advance model across the next rising edge
            rd_next = mem_word(m_fa);
            case (m_ph)
                2'd0: begin
                    m_pc    = m_pc + 1'b1;
                    m_ir    = m_flush ? '0 : m_fw;
                    m_kill  = m_flush;
                    m_flush = 1'b0;
                end
                2'd3: begin
                    m_fw = m_rd_reg;
                    if (bt && !m_kill) begin
                        m_pc = tgt; m_fa = tgt; m_flush = 1'b1;
                    end else begin
                        m_fa = m_pc;
                    end
                end
                default: ;
            endcase
            m_rd_reg = rd_next;
            m_ph = m_ph + 2'd1;
            @(negedge clk);
        end
        br_take = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    // Monitor: pops expectations and compares against the outputs
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk("R1", "phase", 32'(phase), 32'(e.ph));
                chk("R2", "clkout", 32'(clkout), 32'(e.ck));
                chk(e.pc_tag, "pc", 32'(pc), 32'(e.pc));
                chk("R5", "pm_addr", 32'(pm_addr), 32'(e.fa));
                chk(e.ir_tag, "ir", 32'(ir), 32'(e.ir));
                chk(e.dm_tag, "dm_rd", 32'(dm_rd), 32'(e.rd));
                chk(e.dm_tag, "dm_wr", 32'(dm_wr), 32'(e.wr));
            end
        end
    end

    initial begin
        wait (done);
        #1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule